// File: doc/BRIEF.md
# Semaphore-Paced Descriptor DMA Channel

This block is a single DMA channel whose progress is governed by a counting semaphore. Software first loads the address of a command descriptor. It then adds a count to the semaphore. While the count is nonzero and the channel is not held, the channel reads a three-word descriptor from a simple memory read port. It then copies the words of the described buffer onto an output stream. If the command is linked, the channel moves on to the next descriptor through that descriptor's link field.

Each finished command may lower the count by one and may latch a completion flag that feeds an interrupt line. Software can keep adding to the count while the channel runs, so more linked work can be queued without stopping it. A hold input freezes the channel in place. A soft reset input abandons the current command.

Descriptor layout, in bytes from the descriptor address:
- +0: link address.
- +4: command word.
- +8: buffer address.

Memory reads return data one cycle after `mem_rd`. The returned value holds until the next read.

Top module: `dma_chan_seq`

## Requirements
- R1: After `rst_n` is low, the outputs are as follows, and no memory read is issued until the count becomes nonzero:
  - `sem_count` is 0.
  - `busy` is 0.
  - `cmplt_flag` and `irq` are 0.
  - `nxt_addr` is 0.
- R2: A channel that is idle and not held starts when `sem_count` is nonzero. It reads the descriptor at `nxt_addr`, `nxt_addr`+4 and `nxt_addr`+8, in that order.
- R3: Command word bits [31:16] give a length in bytes. The channel emits ceil(length/4) words on `out_data` with `out_valid`, read in order from the buffer address, +4, +8 and so on. A length of 0 emits nothing, but the command still completes.
- R4: When a command completes, `sem_count` drops by one exactly when command bit 6 is set. Otherwise it is unchanged. It never goes below 0.
- R5: A `sem_wr` adds `sem_wdata` to the count, saturating at 255. An add and a completion decrement in the same cycle are both applied.
- R6: When a command with bit 2 set completes, `nxt_addr` takes the descriptor's link field. The channel then fetches the next descriptor if the updated count is nonzero. Otherwise it goes idle and resumes from that address once the count becomes nonzero again.
- R7: When a command with bit 2 clear completes, the channel halts with `busy` low. It ignores a nonzero count until software writes `nxt_addr` through `nxt_wr`.
- R8: While `gate_hold` is high, the channel is frozen:
  - It issues no memory read, no output word and no completion.
  - Its sequence position is kept.
  - Semaphore writes are still applied.
  - Progress resumes where it stopped when `gate_hold` falls.
- R9: `chan_reset` abandons any command in progress and returns the channel to idle with `sem_count` 0. It keeps `nxt_addr` and `cmplt_flag`.
- R10: Each completed command gives a one-cycle `cmd_done` pulse. `cmplt_flag` is set when command bit 3 is set, and `irq` equals `cmplt_flag` AND `irq_en`. `irq_ack` clears the flag, and a same-cycle set wins.
- R11: `busy` is high from the first fetch until the channel goes idle or halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_hold | input | 1 | Freeze the channel while high |
| chan_reset | input | 1 | Soft reset of the channel |
| nxt_wr | input | 1 | Load `nxt_wdata` into the next-descriptor address |
| nxt_wdata | input | 32 | Next-descriptor address to load |
| sem_wr | input | 1 | Add `sem_wdata` to the semaphore |
| sem_wdata | input | SEM_W (8) | Amount to add |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clear the completion flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Byte address of the read |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 32 | Copied buffer word |
| cmd_done | output | 1 | One-cycle pulse per completed command |
| busy | output | 1 | Channel is running a chain |
| sem_count | output | SEM_W (8) | Current semaphore count |
| nxt_addr | output | 32 | Next-descriptor address |
| cmplt_flag | output | 1 | Latched completion flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume two things about the memory. First, it returns read data exactly one cycle after `mem_rd`. Second, it keeps that value until the next read, so a hold that arrives between a read and its capture loses nothing. The bench memory model is a registered array that updates its output only on a read, which matches both. The assertions also assume that `chan_reset` and `sem_wr` are driven away from the clock edge. The bench drives every input on the falling edge. It places the simultaneous add-and-decrement case by waiting for `cmd_done` before raising `sem_wr`.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int WORD_W    = 32;
  localparam int LEN_W     = 16;
  localparam int LEN_LSB   = 16;
  localparam int CHAIN_BIT = 2;
  localparam int IRQ_BIT   = 3;
  localparam int DEC_BIT   = 6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HALT, ST_FNXT, ST_FCMD, ST_FBUF, ST_FEND, ST_XRD, ST_XWR, ST_CMPL
  } seq_state_t;

  typedef struct packed {
    logic [WORD_W-1:0] link;
    logic [LEN_W-1:0]  len;
    logic              chain;
    logic              irq;
    logic              dec;
    logic [WORD_W-1:0] baddr;
  } desc_t;

  // Number of 32-bit words needed to carry len_b bytes (rounded up).
  function automatic logic [LEN_W-1:0] words_for_len(input logic [LEN_W-1:0] len_b);
    logic [LEN_W:0] t;
    t = {1'b0, len_b} + (LEN_W+1)'(3);
    return {1'b0, t[LEN_W:2]};
  endfunction
endpackage

// File: rtl/dma_sem_counter.sv
module dma_sem_counter #(
  parameter int SEM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             add_en,
  input  logic [SEM_W-1:0] add_val,
  input  logic             dec_en,
  output logic [SEM_W-1:0] sem_q,
  output logic [SEM_W-1:0] sem_d
);
  localparam logic [SEM_W+1:0] SEM_MAX = {2'b00, {SEM_W{1'b1}}};

  // Saturating add of a software amount and an optional decrement.
  function automatic logic [SEM_W-1:0] sem_step(input logic [SEM_W-1:0] cur,
                                                input logic [SEM_W-1:0] add,
                                                input logic dec);
    logic [SEM_W+1:0] s;
    s = {2'b00, cur} + {2'b00, add};
    if (dec && (s != '0)) s = s - 1'b1;
    if (s > SEM_MAX) s = SEM_MAX;
    return s[SEM_W-1:0];
  endfunction

  logic [SEM_W-1:0] add_eff;
  assign add_eff = add_en ? add_val : '0;
  assign sem_d   = soft_rst ? '0 : sem_step(sem_q, add_eff, dec_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sem_q <= '0;
    else        sem_q <= sem_d;
  end

  assert_sem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_en && !dec_en && !soft_rst) |=> (sem_q == $past(sem_q)));
  assert_sem_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !add_en && !soft_rst && (sem_q != '0)) |=> (sem_q == $past(sem_q) - 1'b1));
  assert_sem_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !add_en && (sem_q == '0)) |=> (sem_q == '0));
  assert_sem_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (sem_q == '0));
endmodule

// File: rtl/dma_desc_fsm.sv
module dma_desc_fsm
  import dma_seq_pkg::*;
#(
  parameter int SEM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_hold,
  input  logic              soft_rst,
  input  logic              nxt_wr,
  input  logic [WORD_W-1:0] nxt_wdata,
  input  logic [SEM_W-1:0]  sem_q,
  input  logic [SEM_W-1:0]  sem_d,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic [WORD_W-1:0] mem_addr,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              cmd_done,
  output logic              dec_fire,
  output logic              irq_fire,
  output logic              busy,
  output logic [WORD_W-1:0] nxt_addr
);
  localparam logic [WORD_W-1:0] CMD_OFF = WORD_W'(4);
  localparam logic [WORD_W-1:0] BUF_OFF = WORD_W'(8);

  seq_state_t        state;
  desc_t             desc;
  logic [WORD_W-1:0] base;
  logic [WORD_W-1:0] nxt_q;
  logic [LEN_W-1:0]  wcnt;
  logic [LEN_W-1:0]  words;
  logic              run;
  logic              last_word;

  assign words     = words_for_len(desc.len);
  assign run       = !gate_hold && !soft_rst;
  assign last_word = ((wcnt + 1'b1) == words);
  assign nxt_addr  = nxt_q;
  assign busy      = (state != ST_IDLE) && (state != ST_HALT);

  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = '0;
    if (run) begin
      case (state)
        ST_FNXT: begin mem_rd = 1'b1; mem_addr = nxt_q; end
        ST_FCMD: begin mem_rd = 1'b1; mem_addr = base + CMD_OFF; end
        ST_FBUF: begin mem_rd = 1'b1; mem_addr = base + BUF_OFF; end
        ST_XRD:  begin mem_rd = 1'b1; mem_addr = desc.baddr + WORD_W'({wcnt, 2'b00}); end
        default: ;
      endcase
    end
  end

  assign out_valid = run && (state == ST_XWR);
  assign out_data  = mem_rdata;
  assign cmd_done  = run && (state == ST_CMPL);
  assign dec_fire  = cmd_done && desc.dec;
  assign irq_fire  = cmd_done && desc.irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      desc  <= '0;
      base  <= '0;
      nxt_q <= '0;
      wcnt  <= '0;
    end else begin
      if (nxt_wr) nxt_q <= nxt_wdata;
      if (soft_rst) begin
        state <= ST_IDLE;
        wcnt  <= '0;
      end else if (state == ST_HALT) begin
        if (nxt_wr) state <= ST_IDLE;
      end else if (!gate_hold) begin
        case (state)
          ST_IDLE: if (sem_q != '0) state <= ST_FNXT;
          ST_FNXT: begin base <= nxt_q; state <= ST_FCMD; end
          ST_FCMD: begin desc.link <= mem_rdata; state <= ST_FBUF; end
          ST_FBUF: begin
            desc.len   <= mem_rdata[LEN_LSB +: LEN_W];
            desc.chain <= mem_rdata[CHAIN_BIT];
            desc.irq   <= mem_rdata[IRQ_BIT];
            desc.dec   <= mem_rdata[DEC_BIT];
            state      <= ST_FEND;
          end
          ST_FEND: begin
            desc.baddr <= mem_rdata;
            wcnt       <= '0;
            state      <= (words == '0) ? ST_CMPL : ST_XRD;
          end
          ST_XRD: state <= ST_XWR;
          ST_XWR: begin
            wcnt  <= wcnt + 1'b1;
            state <= last_word ? ST_CMPL : ST_XRD;
          end
          ST_CMPL: begin
            if (desc.chain) begin
              nxt_q <= desc.link;
              state <= (sem_d != '0) ? ST_FNXT : ST_IDLE;
            end else begin
              state <= ST_HALT;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && sem_q != '0 && !gate_hold && !soft_rst) |=> (state == ST_FNXT));
  assert_xfer_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (wcnt < words));
  assert_halt_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && !nxt_wr && !soft_rst) |=> (state == ST_HALT));
  assert_gate_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hold && !soft_rst && state != ST_HALT) |=> (state == $past(state)));
  assert_gate_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hold |-> (!mem_rd && !out_valid && !cmd_done));
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (state == ST_IDLE));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
endmodule

// File: rtl/dma_cmplt_flag.sv
module dma_cmplt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic ack,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_en) flag <= 1'b1;
    else if (ack)    flag <= 1'b0;
  end

  assign irq = flag && irq_en;

  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> flag);
  assert_flag_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_en) |=> !flag);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int SEM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_hold,
  input  logic              chan_reset,
  input  logic              nxt_wr,
  input  logic [WORD_W-1:0] nxt_wdata,
  input  logic              sem_wr,
  input  logic [SEM_W-1:0]  sem_wdata,
  input  logic              irq_en,
  input  logic              irq_ack,
  output logic              mem_rd,
  output logic [WORD_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              cmd_done,
  output logic              busy,
  output logic [SEM_W-1:0]  sem_count,
  output logic [WORD_W-1:0] nxt_addr,
  output logic              cmplt_flag,
  output logic              irq
);
  logic [SEM_W-1:0] sem_d;
  logic             dec_fire;
  logic             irq_fire;

  dma_sem_counter #(.SEM_W(SEM_W)) u_sem (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (chan_reset),
    .add_en   (sem_wr),
    .add_val  (sem_wdata),
    .dec_en   (dec_fire),
    .sem_q    (sem_count),
    .sem_d    (sem_d)
  );

  dma_desc_fsm #(.SEM_W(SEM_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_hold (gate_hold),
    .soft_rst  (chan_reset),
    .nxt_wr    (nxt_wr),
    .nxt_wdata (nxt_wdata),
    .sem_q     (sem_count),
    .sem_d     (sem_d),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .out_valid (out_valid),
    .out_data  (out_data),
    .cmd_done  (cmd_done),
    .dec_fire  (dec_fire),
    .irq_fire  (irq_fire),
    .busy      (busy),
    .nxt_addr  (nxt_addr)
  );

  dma_cmplt_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (irq_fire),
    .ack    (irq_ack),
    .irq_en (irq_en),
    .flag   (cmplt_flag),
    .irq    (irq)
  );

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);
endmodule

// File: tb/sim_dma_chan_seq.sv
`timescale 1ns/1ps
module sim_dma_chan_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gate_hold = 1'b0, chan_reset = 1'b0, nxt_wr = 1'b0, sem_wr = 1'b0;
  logic [31:0] nxt_wdata = '0;
  logic [7:0]  sem_wdata = '0;
  logic        irq_en = 1'b0, irq_ack = 1'b0;
  logic        mem_rd, out_valid, cmd_done, busy, cmplt_flag, irq;
  logic [31:0] mem_addr, out_data, nxt_addr;
  logic [31:0] mem_rdata = '0;
  logic [7:0]  sem_count;

  always #2.5 clk = ~clk;

  dma_chan_seq u0 (
    .clk(clk), .rst_n(rst_n), .gate_hold(gate_hold), .chan_reset(chan_reset),
    .nxt_wr(nxt_wr), .nxt_wdata(nxt_wdata), .sem_wr(sem_wr), .sem_wdata(sem_wdata),
    .irq_en(irq_en), .irq_ack(irq_ack), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
    .cmd_done(cmd_done), .busy(busy), .sem_count(sem_count), .nxt_addr(nxt_addr),
    .cmplt_flag(cmplt_flag), .irq(irq)
  );

  logic [31:0] mem [0:255];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];

  int total = 0, fails = 0, cyc = 0;
  int got = 0, done_cnt = 0, mism = 0, nrd = 0;
  int exp_base = 0, rd_base = 0;
  logic [31:0] exp_w [0:127];
  logic [31:0] rd_log [0:3];

  always @(posedge clk) begin
    if (out_valid) begin
      if ((got - exp_base) < 128 && out_data !== exp_w[got - exp_base]) mism++;
      got++;
    end
    if (cmd_done) done_cnt++;
    if (mem_rd) begin
      if ((nrd - rd_base) < 4) rd_log[nrd - rd_base] = mem_addr;
      nrd++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // Command word: len [31:16], chain bit 2, irq bit 3, dec bit 6.
  localparam int TAB [6][4] = '{  // sem, ndesc, len bytes, dec
    '{1, 1, 8, 1}, '{3, 2, 12, 1}, '{2, 3, 4, 1},
    '{1, 2, 16, 0}, '{1, 1, 0, 1}, '{4, 2, 5, 1}
  };

  function automatic logic [31:0] daddr(int k); return 32'h40 + 32'(16 * k); endfunction
  function automatic logic [31:0] baddr(int k); return 32'h200 + 32'(64 * k); endfunction
  function automatic int wc(int len); return (len + 3) / 4; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic build(int n, int len, bit dec, bit irqb);
    for (int k = 0; k < n; k++) begin
      mem[daddr(k) >> 2]       = daddr(k + 1);
      mem[(daddr(k) >> 2) + 1] = {16'(len), 16'h0} | ((k < n - 1) ? 32'h4 : 32'h0) |
                                 (dec ? 32'h40 : 32'h0) | (irqb ? 32'h8 : 32'h0);
      mem[(daddr(k) >> 2) + 2] = baddr(k);
    end
  endtask

  task automatic prep(int nexec, int len);
    int idx = 0;
    exp_base = got;
    rd_base = nrd;
    for (int k = 0; k < nexec; k++)
      for (int w = 0; w < wc(len); w++) begin
        exp_w[idx] = mem[(baddr(k) >> 2) + w];
        idx++;
      end
  endtask

  task automatic wr_nxt(logic [31:0] a);
    @(negedge clk); nxt_wr = 1'b1; nxt_wdata = a;
    @(negedge clk); nxt_wr = 1'b0;
  endtask

  task automatic wr_sem(logic [7:0] v);
    @(negedge clk); sem_wr = 1'b1; sem_wdata = v;
    @(negedge clk); sem_wr = 1'b0;
  endtask

  task automatic soft_reset();
    @(negedge clk); chan_reset = 1'b1;
    @(negedge clk); chan_reset = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 3000 && q < 12; i++) begin
      @(negedge clk);
      if (busy) q = 0; else q++;
    end
  endtask

  task automatic wait_words(int n);
    for (int i = 0; i < 2000 && (got - exp_base) < n; i++) @(negedge clk);
  endtask

  initial begin
    int d0, m0, g, ex, semf, kch;
    for (int i = 0; i < 256; i++) mem[i] = 32'hB000_0000 + 32'(i * 257);

    repeat (4) @(negedge clk);
    chk("R1 sem after reset", 32'(sem_count), 0);
    chk("R1 busy after reset", 32'(busy), 0);
    chk("R1 flag after reset", 32'(cmplt_flag), 0);
    chk("R1 irq after reset", 32'(irq), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 nxt after reset", nxt_addr, 0);
    chk("R1 no reads while count zero", 32'(nrd), 0);

    for (int r = 0; r < 6; r++) begin
      ex   = TAB[r][3] ? ((TAB[r][0] < TAB[r][1]) ? TAB[r][0] : TAB[r][1]) : TAB[r][1];
      semf = TAB[r][3] ? TAB[r][0] - ex : TAB[r][0];
      kch  = (ex == TAB[r][1]) ? ex - 1 : ex;
      soft_reset();
      build(TAB[r][1], TAB[r][2], TAB[r][3] != 0, 1'b1);
      prep(ex, TAB[r][2]);
      d0 = done_cnt; m0 = mism;
      wr_nxt(daddr(0));
      wr_sem(8'(TAB[r][0]));
      wait_idle();
      chk($sformatf("R10 row %0d done count", r), 32'(done_cnt - d0), 32'(ex));
      chk($sformatf("R3 row %0d word count", r), 32'(got - exp_base), 32'(ex * wc(TAB[r][2])));
      chk($sformatf("R3 row %0d data mismatches", r), 32'(mism - m0), 0);
      chk($sformatf("R4 row %0d final count", r), 32'(sem_count), 32'(semf));
      chk($sformatf("R6 row %0d next address", r), nxt_addr, daddr(kch));
      chk($sformatf("R2 row %0d first fetch", r), rd_log[0], daddr(0));
      chk($sformatf("R2 row %0d third fetch", r), rd_log[2], daddr(0) + 8);
    end

    // R8: hold before start, writes still counted
    soft_reset();
    build(1, 32, 1'b1, 1'b1);
    prep(1, 32);
    @(negedge clk); gate_hold = 1'b1;
    wr_nxt(daddr(0));
    wr_sem(8'd1);
    repeat (20) @(negedge clk);
    chk("R8 no words while held", 32'(got - exp_base), 0);
    chk("R8 not busy while held at idle", 32'(busy), 0);
    chk("R8 count kept while held", 32'(sem_count), 1);
    wr_sem(8'd200);
    wr_sem(8'd100);
    chk("R5 count saturates at 255", 32'(sem_count), 255);
    soft_reset();
    chk("R9 reset clears count", 32'(sem_count), 0);
    @(negedge clk); gate_hold = 1'b0;

    // R8: hold in mid transfer
    prep(1, 32);
    d0 = done_cnt; m0 = mism;
    wr_sem(8'd1);
    wait_words(2);
    gate_hold = 1'b1;
    g = got;
    repeat (20) @(negedge clk);
    chk("R8 words frozen mid transfer", 32'(got), 32'(g));
    chk("R11 busy while frozen", 32'(busy), 1);
    gate_hold = 1'b0;
    wait_idle();
    chk("R8 all words after release", 32'(got - exp_base), 8);
    chk("R8 data after release", 32'(mism - m0), 0);
    chk("R8 one completion", 32'(done_cnt - d0), 1);

    // R9: abort mid command
    soft_reset();
    build(1, 64, 1'b1, 1'b1);
    prep(1, 64);
    d0 = done_cnt;
    wr_nxt(daddr(0));
    wr_sem(8'd3);
    wait_words(2);
    soft_reset();
    repeat (20) @(negedge clk);
    g = got;
    repeat (10) @(negedge clk);
    chk("R9 output stopped", 32'(got), 32'(g));
    chk("R9 words cut short", 32'((got - exp_base) < 16), 1);
    chk("R9 idle after abort", 32'(busy), 0);
    chk("R9 count cleared", 32'(sem_count), 0);
    chk("R9 no completion", 32'(done_cnt - d0), 0);
    chk("R9 next address kept", nxt_addr, daddr(0));

    // R5: add during the decrement cycle
    soft_reset();
    build(3, 4, 1'b1, 1'b1);
    prep(3, 4);
    d0 = done_cnt;
    wr_nxt(daddr(0));
    wr_sem(8'd1);
    for (int i = 0; i < 500 && !cmd_done; i++) @(negedge clk);
    sem_wr = 1'b1; sem_wdata = 8'd2;
    @(negedge clk); sem_wr = 1'b0;
    chk("R5 add and decrement same cycle", 32'(sem_count), 2);
    wait_idle();
    chk("R5 queued commands all run", 32'(done_cnt - d0), 3);
    chk("R4 count back to zero", 32'(sem_count), 0);

    // R7: halt after an unlinked command
    soft_reset();
    build(1, 4, 1'b0, 1'b1);
    prep(1, 4);
    exp_w[1] = exp_w[0];
    d0 = done_cnt;
    wr_nxt(daddr(0));
    wr_sem(8'd2);
    wait_idle();
    chk("R7 one command then halt", 32'(done_cnt - d0), 1);
    chk("R4 no decrement without flag", 32'(sem_count), 2);
    repeat (30) @(negedge clk);
    chk("R7 halt ignores nonzero count", 32'(done_cnt - d0), 1);
    wr_nxt(daddr(0));
    wait_idle();
    chk("R7 address write releases halt", 32'(done_cnt - d0), 2);

    // R6: idle at count zero mid chain, then resume
    soft_reset();
    build(2, 4, 1'b1, 1'b1);
    prep(2, 4);
    d0 = done_cnt; m0 = mism;
    wr_nxt(daddr(0));
    wr_sem(8'd1);
    wait_idle();
    chk("R6 stops when count empties", 32'(done_cnt - d0), 1);
    chk("R6 link address loaded", nxt_addr, daddr(1));
    wr_sem(8'd1);
    wait_idle();
    chk("R6 resumes at linked descriptor", 32'(done_cnt - d0), 2);
    chk("R6 resumed data", 32'(mism - m0), 0);

    // R10: flag, enable, acknowledge
    chk("R10 flag set", 32'(cmplt_flag), 1);
    chk("R10 irq masked", 32'(irq), 0);
    @(negedge clk); irq_en = 1'b1;
    @(negedge clk);
    chk("R10 irq when enabled", 32'(irq), 1);
    irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R10 ack clears flag", 32'(cmplt_flag), 0);
    chk("R10 ack clears irq", 32'(irq), 0);
    soft_reset();
    build(1, 4, 1'b1, 1'b0);
    prep(1, 4);
    d0 = done_cnt;
    wr_nxt(daddr(0));
    wr_sem(8'd1);
    wait_idle();
    chk("R10 completion without irq bit", 32'(done_cnt - d0), 1);
    chk("R10 flag stays clear", 32'(cmplt_flag), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule